// File: doc/BRIEF.md
# Incremental Encoder Position and Pulse-Period Speed Interface

This block sits between the two channel inputs of an incremental quadrature encoder and the logic that needs a position and a speed figure. Each channel is brought into the clock domain by a two-register synchronizer and then passes a debounce filter. A run-time code selects the filter: off, 1 µs or 2 µs. A longer filter gives more immunity to glitches but lowers the highest pulse rate the block can follow. The filtered A/B pair is decoded into a signed step that moves a wrapping position counter on every accepted transition.

Speed is reported as a period. This is the number of clock cycles between two consecutive rising edges of the filtered A channel. Each new value is announced by a one-cycle strobe. A millisecond prescaler drives a no-edge timer. If no rising edge of A arrives within the programmed waiting time, the period output is forced to zero and the zero-speed flag is raised. The position path is never affected by this timer. The waiting time is given in whole milliseconds and clamped to 1..200. A fixed-4 ms input restores the legacy behaviour. Converting the period to engineering units is left to the consumer.

Top module: `enc_speed_if`

## Requirements
- R1: A filtered channel takes a new level only after its synchronized input has differed from the current filtered level for N consecutive cycles. N is 0 for select code 0, CLK_KHZ/1000 for code 1, and 2*CLK_KHZ/1000 for codes 2 and 3. A shorter glitch leaves the position unchanged.
- R2: With select code 0, a channel change driven before a clock edge shows on `pos` after the fourth rising edge and not before.
- R3: With {A,B} as a two-bit value, the sequence 00→01→11→10→00 increments `pos` by one per transition. The reverse sequence decrements it. `pos` wraps modulo 2^POS_W and resets to 0.
- R4: A transition in which both filtered channels change at once leaves `pos` unchanged.
- R5: `period` is the number of cycles between two consecutive rising edges of filtered A. Each new value is published with `period_vld` high for exactly one cycle. The first rising edge after reset or after a timeout only arms the measurement and publishes nothing.
- R6: `zero_spd` is 1 out of reset and clears only when a period is published.
- R7: If no rising edge of filtered A occurs for the effective waiting time (in milliseconds of CLK_KHZ cycles each), `zero_spd` goes to 1 and `period` goes to 0. Position keeps updating on every accepted transition.
- R8: The effective waiting time resets to 4 ms. While `wait_fixed` is 1 it is 4 ms regardless of `wait_ms`.
- R9: A `wait_ms` value of 0 acts as 1. A value above 200 acts as 200.
- R10: With select code 2, quadrature pulses at 200 kHz on each channel are counted without loss, and their period is measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| filt_sel | input | 2 | Filter select: 0 off, 1 1 µs, 2 or 3 2 µs |
| wait_ms | input | 8 | No-edge waiting time in ms, clamped to 1..200 |
| wait_fixed | input | 1 | Forces a 4 ms waiting time when 1 |
| pos | output | POS_W | Wrapping position count |
| period | output | PER_W | Cycles between rising edges of filtered A, 0 when stopped |
| period_vld | output | 1 | One-cycle strobe for a new period |
| zero_spd | output | 1 | Speed is zero (no measurement or timeout) |

## Verification
A filter counter that is stuck or miscounted shows up as a position change arriving a cycle early or late, or as an accepted glitch. This is visible at `pos` within a few cycles of the input change. A decoder phase error turns into a wrong count, or a wrong sign, on the next transition. A bad millisecond or period counter only shows as a wrong `period` on the next publish, or as a `zero_spd` change at the wrong cycle up to one full waiting time later. The bench therefore compares every output against a behavioural model on each cycle, so a slip of a single cycle is reported.

// File: rtl/enc_pkg.sv
package enc_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_SHORT    = 2'd1,
        FLT_LONG     = 2'd2,
        FLT_LONG_ALT = 2'd3
    } flt_sel_e;

    localparam logic [7:0] WAIT_MIN = 8'd1;
    localparam logic [7:0] WAIT_MAX = 8'd200;
    localparam logic [7:0] WAIT_DEF = 8'd4;

    // Clamp a requested waiting time into the legal window.
    function automatic logic [7:0] clamp_wait(input logic [7:0] req);
        logic [7:0] r;
        if (req < WAIT_MIN)      r = WAIT_MIN;
        else if (req > WAIT_MAX) r = WAIT_MAX;
        else                     r = req;
        return r;
    endfunction

    // Map an {A,B} level pair to a phase index 0..3 along the forward order.
    function automatic logic [1:0] quad_phase(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

endpackage

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter
    import enc_pkg::*;
#(
    parameter int US_CYC = 250,
    parameter int CNT_W  = $clog2(2 * US_CYC + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [1:0] sel,
    output logic       lvl
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [CNT_W-1:0] run;
    } filt_t;

    filt_t            cur_q, nxt_d;
    logic [CNT_W-1:0] need;
    logic [CNT_W:0]   run_inc;

    always_comb begin
        case (flt_sel_e'(sel))
            FLT_NONE:  need = '0;
            FLT_SHORT: need = CNT_W'(US_CYC);
            default:   need = CNT_W'(2 * US_CYC);
        endcase
    end

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = raw;
        nxt_d.s2 = cur_q.s1;
        run_inc  = {1'b0, cur_q.run} + 1'b1;
        if (cur_q.s2 == cur_q.lvl) begin
            nxt_d.run = '0;
        end else if (run_inc >= {1'b0, need}) begin
            nxt_d.lvl = cur_q.s2;
            nxt_d.run = '0;
        end else begin
            nxt_d.run = run_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign lvl = cur_q.lvl;

    AST_FILT_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.lvl != $past(cur_q.lvl)) |-> (cur_q.lvl == $past(cur_q.s2))); // R1
    AST_FILT_NO_FAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != 2'd0) && (cur_q.s2 != cur_q.lvl) && (cur_q.run == '0)) |=> $stable(cur_q.lvl)); // R1

endmodule

// File: rtl/enc_quad_counter.sv
module enc_quad_counter
    import enc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fa,
    input  logic             fb,
    output logic [POS_W-1:0] pos
);

    typedef struct packed {
        logic             pa;
        logic             pb;
        logic [POS_W-1:0] pos;
    } quad_t;

    quad_t      cur_q, nxt_d;
    logic [1:0] ph_old, ph_new, ph_diff;

    always_comb begin
        nxt_d   = cur_q;
        ph_old  = quad_phase(cur_q.pa, cur_q.pb);
        ph_new  = quad_phase(fa, fb);
        ph_diff = ph_new - ph_old;
        case (ph_diff)
            2'd1:    nxt_d.pos = cur_q.pos + POS_W'(1);
            2'd3:    nxt_d.pos = cur_q.pos - POS_W'(1);
            default: nxt_d.pos = cur_q.pos;   // no move, or an illegal double change
        endcase
        nxt_d.pa = fa;
        nxt_d.pb = fb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pos = cur_q.pos;

    AST_POS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.pos != $past(cur_q.pos)) |->
        (((cur_q.pos - $past(cur_q.pos)) == POS_W'(1)) ||
         (($past(cur_q.pos) - cur_q.pos) == POS_W'(1)))); // R3
    AST_JUMP_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ((fa != cur_q.pa) && (fb != cur_q.pb)) |=> $stable(cur_q.pos)); // R4

endmodule

// File: rtl/enc_period_timer.sv
module enc_period_timer
    import enc_pkg::*;
#(
    parameter int MS_CYC = 250000,
    parameter int PER_W  = 26,
    parameter int PRE_W  = (MS_CYC > 1) ? $clog2(MS_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fa,
    input  logic [7:0]       wait_ms,
    input  logic             wait_fixed,
    output logic [PER_W-1:0] period,
    output logic             period_vld,
    output logic             zero_spd
);

    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_CYC - 1);

    typedef struct packed {
        logic             a_prev;
        logic             armed;
        logic             vld;
        logic             zero;
        logic [7:0]       lim;
        logic [7:0]       ms;
        logic [PRE_W-1:0] pre;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } tmr_t;

    tmr_t       cur_q, nxt_d;
    logic       rise;
    logic       tick;
    logic [8:0] ms_inc;

    always_comb begin
        nxt_d        = cur_q;
        rise         = fa & ~cur_q.a_prev;
        tick         = (cur_q.pre == PRE_LAST);
        ms_inc       = {1'b0, cur_q.ms} + 9'd1;
        nxt_d.a_prev = fa;
        nxt_d.vld    = 1'b0;
        nxt_d.lim    = wait_fixed ? WAIT_DEF : clamp_wait(wait_ms);
        if (rise) begin
            if (cur_q.armed) begin
                nxt_d.per  = cur_q.cnt;
                nxt_d.vld  = 1'b1;
                nxt_d.zero = 1'b0;
            end
            nxt_d.armed = 1'b1;
            nxt_d.cnt   = PER_W'(1);
            nxt_d.pre   = '0;
            nxt_d.ms    = '0;
        end else begin
            if (cur_q.cnt != '1) nxt_d.cnt = cur_q.cnt + PER_W'(1);
            if (tick) begin
                nxt_d.pre = '0;
                if (cur_q.ms != 8'hFF) nxt_d.ms = ms_inc[7:0];
                if (ms_inc >= {1'b0, cur_q.lim}) begin
                    nxt_d.zero  = 1'b1;
                    nxt_d.per   = '0;
                    nxt_d.armed = 1'b0;
                end
            end else begin
                nxt_d.pre = cur_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.zero <= 1'b1;
            cur_q.lim  <= WAIT_DEF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign period     = cur_q.per;
    assign period_vld = cur_q.vld;
    assign zero_spd   = cur_q.zero;

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.vld |=> !cur_q.vld); // R5
    AST_VLD_CLEARS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.vld |-> !cur_q.zero); // R6
    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.zero |-> (cur_q.per == '0)); // R7
    AST_FIXED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wait_fixed) |-> (cur_q.lim == WAIT_DEF)); // R8
    AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.lim >= WAIT_MIN) && (cur_q.lim <= WAIT_MAX)); // R9

endmodule

// File: rtl/enc_speed_if.sv
module enc_speed_if
    import enc_pkg::*;
#(
    parameter int CLK_KHZ = 250000,
    parameter int POS_W   = 16,
    parameter int PER_W   = $clog2(200 * CLK_KHZ + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic [1:0]       filt_sel,
    input  logic [7:0]       wait_ms,
    input  logic             wait_fixed,
    output logic [POS_W-1:0] pos,
    output logic [PER_W-1:0] period,
    output logic             period_vld,
    output logic             zero_spd
);

    localparam int US_CYC = (CLK_KHZ >= 1000) ? CLK_KHZ / 1000 : 1;
    localparam int MS_CYC = (CLK_KHZ >= 2) ? CLK_KHZ : 2;
    localparam int NCH    = 2;

    logic [NCH-1:0] raw_ch;
    logic [NCH-1:0] flt_ch;

    assign raw_ch = {enc_b, enc_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        enc_glitch_filter #(.US_CYC(US_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_ch[ch]),
            .sel   (filt_sel),
            .lvl   (flt_ch[ch])
        );
    end

    enc_quad_counter #(.POS_W(POS_W)) u_quad (
        .clk   (clk),
        .rst_n (rst_n),
        .fa    (flt_ch[0]),
        .fb    (flt_ch[1]),
        .pos   (pos)
    );

    enc_period_timer #(.MS_CYC(MS_CYC), .PER_W(PER_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fa         (flt_ch[0]),
        .wait_ms    (wait_ms),
        .wait_fixed (wait_fixed),
        .period     (period),
        .period_vld (period_vld),
        .zero_spd   (zero_spd)
    );

endmodule

// File: tb/enc_speed_if_test.sv
`timescale 1ns/1ps
module enc_speed_if_test;

    localparam int KHZ  = 8000;           // scaled clock rate seen by the design
    localparam int US   = KHZ / 1000;
    localparam int MS   = KHZ;
    localparam int PW   = $clog2(200 * KHZ + 1) + 1;
    localparam longint PMAX = (64'd1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0]    filt_sel = 2'd0;
    logic [7:0]    wait_ms = 8'd4;
    logic          wait_fixed = 1'b0;
    logic [15:0]   pos;
    logic [PW-1:0] period;
    logic          period_vld;
    logic          zero_spd;

    int nerr = 0, nchk = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    enc_speed_if #(.CLK_KHZ(KHZ), .POS_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .filt_sel(filt_sel), .wait_ms(wait_ms), .wait_fixed(wait_fixed),
        .pos(pos), .period(period), .period_vld(period_vld), .zero_spd(zero_spd)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int s1[2], s2[2], fl[2], run[2];
    int m_pa, m_pb, m_pos, m_armed, m_vld, m_zero, m_lim, m_ms, m_pre, m_per;
    longint m_cnt;
    int need, ph_o, ph_n, d, rin[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin s1[c] = 0; s2[c] = 0; fl[c] = 0; run[c] = 0; end
            m_pa = 0; m_pb = 0; m_pos = 0; m_armed = 0; m_vld = 0; m_zero = 1;
            m_lim = 4; m_ms = 0; m_pre = 0; m_per = 0; m_cnt = 0;
        end else begin
            // speed side, from the previous filtered A
            if (fl[0] == 1 && m_pa == 0) begin
                if (m_armed == 1) begin m_per = int'(m_cnt); m_vld = 1; m_zero = 0; end
                else m_vld = 0;
                m_armed = 1; m_cnt = 1; m_pre = 0; m_ms = 0;
            end else begin
                m_vld = 0;
                if (m_cnt < PMAX) m_cnt++;
                if (m_pre == MS - 1) begin
                    m_pre = 0;
                    if (m_ms < 255) m_ms++;
                    if (m_ms >= m_lim) begin m_zero = 1; m_per = 0; m_armed = 0; end
                end else m_pre++;
            end
            m_lim = wait_fixed ? 4 : (wait_ms == 0 ? 1 : (wait_ms > 200 ? 200 : int'(wait_ms)));
            // position side
            ph_o = m_pa * 2 + (m_pa ^ m_pb);
            ph_n = fl[0] * 2 + (fl[0] ^ fl[1]);
            d = (ph_n - ph_o + 4) % 4;
            if (d == 1) m_pos = (m_pos + 1) % 65536;
            else if (d == 3) m_pos = (m_pos + 65535) % 65536;
            m_pa = fl[0]; m_pb = fl[1];
            // filters
            need = (filt_sel == 0) ? 0 : (filt_sel == 1 ? US : 2 * US);
            for (int c = 0; c < 2; c++) begin
                if (s2[c] == fl[c]) run[c] = 0;
                else begin
                    run[c]++;
                    if (run[c] >= need) begin fl[c] = s2[c]; run[c] = 0; end
                end
            end
            rin[0] = int'(enc_a); rin[1] = int'(enc_b);
            for (int c = 0; c < 2; c++) begin s2[c] = s1[c]; s1[c] = rin[c]; end
        end
    end

    longint last_per = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pos == 16'(m_pos), "R3 pos vs model", pos, m_pos);
            chk(period == PW'(m_per), "R5 period vs model", period, m_per);
            chk(period_vld == 1'(m_vld), "R5 strobe vs model", period_vld, m_vld);
            chk(zero_spd == 1'(m_zero), "R7 zero_spd vs model", zero_spd, m_zero);
            if (period_vld) last_per = period;
        end
    end

    // ---------------- stimulus ----------------
    logic [1:0] g = 2'd0;
    int exp_pos = 0;

    task automatic drive_g();
        enc_a = g[1];
        enc_b = g[1] ^ g[0];
    endtask

    task automatic step(input int dir, input int hold);
        g = (dir > 0) ? g + 2'd1 : g - 2'd1;
        exp_pos = (exp_pos + dir + 65536) % 65536;
        drive_g();
        repeat (hold) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pos == 0, "R3 reset pos", pos, 0);
        chk(zero_spd == 1, "R6 reset zero_spd", zero_spd, 1);
        chk(period_vld == 0, "R5 reset strobe", period_vld, 0);
        chk(period == 0, "R7 reset period", period, 0);

        // R2: latency with no filter
        p0 = exp_pos;
        g = g + 2'd1; exp_pos++; drive_g();
        idle(3);
        chk(pos == 16'(p0), "R2 pos before 4th edge", pos, p0);
        idle(1);
        chk(pos == 16'(p0 + 1), "R2 pos after 4th edge", pos, p0 + 1);
        idle(10);

        // R3: forward and reverse
        for (int i = 0; i < 8; i++) step(1, 20);
        chk(pos == 16'(exp_pos), "R3 forward count", pos, exp_pos);
        for (int i = 0; i < 3; i++) step(-1, 20);
        chk(pos == 16'(exp_pos), "R3 reverse count", pos, exp_pos);

        // R4: double change ignored
        g = g + 2'd2; drive_g(); idle(20);
        chk(pos == 16'(exp_pos), "R4 double change", pos, exp_pos);
        step(1, 20);
        chk(pos == 16'(exp_pos), "R4 count resumes", pos, exp_pos);

        // R1: glitches shorter than the filter are rejected
        filt_sel = 2'd1;
        enc_a = ~enc_a; idle(US - 2); enc_a = ~enc_a; idle(30);
        chk(pos == 16'(exp_pos), "R1 short glitch, 1 us", pos, exp_pos);
        filt_sel = 2'd2;
        enc_b = ~enc_b; idle(2 * US - 2); enc_b = ~enc_b; idle(40);
        chk(pos == 16'(exp_pos), "R1 glitch, 2 us", pos, exp_pos);
        filt_sel = 2'd3;
        enc_a = ~enc_a; idle(2 * US - 2); enc_a = ~enc_a; idle(40);
        chk(pos == 16'(exp_pos), "R1 glitch, code 3", pos, exp_pos);
        filt_sel = 2'd1;
        step(1, 3 * US);
        chk(pos == 16'(exp_pos), "R1 held level accepted", pos, exp_pos);

        // R5: period under no filter
        filt_sel = 2'd0;
        for (int i = 0; i < 12; i++) step(1, 25);
        idle(5);
        chk(last_per == 100, "R5 period 100 cycles", last_per, 100);
        chk(zero_spd == 0, "R6 cleared after publish", zero_spd, 0);

        // R10: 200 kHz with the 2 us filter (40 cycles per pulse)
        filt_sel = 2'd2;
        p0 = exp_pos;
        for (int i = 0; i < 20; i++) step(1, 10);
        idle(40);
        chk(pos == 16'(exp_pos), "R10 pos at 200 kHz", pos, exp_pos);
        chk(last_per == 40, "R10 period at 200 kHz", last_per, 40);
        filt_sel = 2'd0;

        // R7: timeout at 1 ms, position still moves
        wait_ms = 8'd1;
        idle(MS + 200);
        chk(zero_spd == 1, "R7 timeout flag", zero_spd, 1);
        chk(period == 0, "R7 period zeroed", period, 0);
        step(1, 10);
        chk(pos == 16'(exp_pos), "R7 pos updates while stopped", pos, exp_pos);
        chk(zero_spd == 1, "R5 first edge only arms", zero_spd, 1);
        for (int i = 0; i < 8; i++) step(1, 25);
        chk(zero_spd == 0 && last_per == 100, "R6 restart publishes", last_per, 100);

        // R9: 0 acts as 1 ms
        wait_ms = 8'd0;
        for (int i = 0; i < 8; i++) step(1, 25);
        idle(MS - 200);
        chk(zero_spd == 0, "R9 no early timeout at 0", zero_spd, 0);
        idle(300);
        chk(zero_spd == 1, "R9 value 0 times out at 1 ms", zero_spd, 1);

        // R9: 255 acts as 200 ms (no timeout after 1 ms)
        wait_ms = 8'd255;
        for (int i = 0; i < 8; i++) step(1, 25);
        idle(MS + 1000);
        chk(zero_spd == 0, "R9 value 255 clamped high", zero_spd, 0);

        // R8: fixed 4 ms overrides wait_ms
        wait_ms = 8'd1;
        wait_fixed = 1'b1;
        for (int i = 0; i < 8; i++) step(1, 25);
        idle(2 * MS);
        chk(zero_spd == 0, "R8 no timeout before 4 ms", zero_spd, 0);
        idle(2 * MS + 400);
        chk(zero_spd == 1, "R8 timeout at 4 ms", zero_spd, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule